// File: doc/BRIEF.md
# Per-Frame RGB Gray-Level Histogram Engine

This block watches a 24-bit RGB pixel stream on the pixel clock. For every frame it counts how many active pixels land on each 8-bit gray level, with a separate 256-bin histogram for the red, green and blue components. A pixel is counted only while the data-enable input is high. Each channel decodes its 8-bit value one-hot, so exactly one of its counters advances per active pixel.

On a rising edge of the vertical sync input, the counts gathered so far are frozen into a held bank. The live counters then start the new frame from zero. A single-cycle `frame_done` pulse tells downstream logic that a fresh bank is ready.

Downstream logic scans the held bank through a small synchronous read port: a channel select, a bin address and a registered data output. Counting continues at full pixel rate while the previous frame's histogram is being read.

Top module: `rgb_hist_engine`

## Requirements
- R1: After synchronous reset, `frame_done` is 0, `rd_data` is 0, and every held bin of every channel reads as 0.
- R2: Each active pixel adds one to the bin equal to its component value in each channel. Red is `pix_rgb[23:16]`, green is `pix_rgb[15:8]` and blue is `pix_rgb[7:0]`.
- R3: A pixel presented while `pix_de` is 0 changes no count, whatever its value.
- R4: In the cycle where `pix_vsync` is 1 and was 0 in the cycle before, the live counts are copied into the held bank. `frame_done` is 1 for exactly the one clock after that edge. Holding `pix_vsync` high or lowering it raises no further pulse.
- R5: After a swap, the live counts restart from zero. An active pixel presented in the swap cycle itself belongs to the new frame.
- R6: Between two swaps, the held bank does not change, so repeated reads of one bin return the same value while the next frame is being counted.
- R7: A read has one clock of latency: `rd_data` shows the bin addressed at the previous clock edge. Channel select 0, 1 and 2 pick red, green and blue. Select 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_de | input | 1 | Data enable; the pixel is counted when high |
| pix_vsync | input | 1 | Vertical sync; its rising edge ends a frame |
| pix_rgb | input | 24 | Pixel value, red in the top byte, blue in the bottom byte |
| rd_ch | input | 2 | Read channel select (0 red, 1 green, 2 blue, 3 none) |
| rd_addr | input | 8 | Read bin address (gray level) |
| rd_data | output | 21 | Registered count of the addressed held bin |
| frame_done | output | 1 | One-clock pulse when a new held bank is valid |

## Verification
The assertions check the following on every cycle:
- `frame_done` is a single-clock pulse that tracks each rising edge of vertical sync.
- An unused channel select always reads back zero.
- The read output holds steady while address and channel are unchanged and no swap has occurred.

The exact bin counts can only be shown by the bench's scenarios. These cover mixed frames with blanked pixels, the pixel that coincides with the swap edge, and full-length ramp lines. In each case a frame is scanned through the read port and compared against an independent model.

// File: rtl/rgb_hist_pkg.sv
`timescale 1ns/1ps
package rgb_hist_pkg;
  localparam int NUM_CH   = 3;
  localparam int CH_SEL_W = 2;

  typedef enum logic [CH_SEL_W-1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2,
    CH_NONE  = 2'd3
  } ch_sel_e;
endpackage

// File: rtl/hist_frame_sync.sv
`timescale 1ns/1ps
module hist_frame_sync (
  input  logic clk,
  input  logic rst,
  input  logic vsync_in,
  output logic swap,
  output logic bank_ready
);
  logic vsync_q;

  // Frame boundary: vsync high now, low one cycle ago.
  assign swap = vsync_in & ~vsync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_q    <= 1'b0;
      bank_ready <= 1'b0;
    end else begin
      vsync_q    <= vsync_in;
      bank_ready <= swap;
    end
  end
endmodule

// File: rtl/hist_channel.sv
`timescale 1ns/1ps
module hist_channel #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_val,
  input  logic             pix_en,
  input  logic             swap,
  input  logic [PIX_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_bin
);
  localparam int BINS = 1 << PIX_W;

  logic [BINS-1:0]  hit;
  logic [CNT_W-1:0] held_view [BINS];

  // One-hot decode of the gray level: at most one bin advances per clock.
  always_comb begin
    hit = '0;
    if (pix_en) hit[pix_val] = 1'b1;
  end

  for (genvar b = 0; b < BINS; b++) begin : g_bin
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] held_cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        live_cnt <= '0;
        held_cnt <= '0;
      end else if (swap) begin
        held_cnt <= live_cnt;
        live_cnt <= hit[b] ? CNT_W'(1) : '0;
      end else if (hit[b]) begin
        live_cnt <= live_cnt + CNT_W'(1);
      end
    end

    assign held_view[b] = held_cnt;
  end

  assign rd_bin = held_view[rd_addr];
endmodule

// File: rtl/hist_read_port.sv
`timescale 1ns/1ps
module hist_read_port
  import rgb_hist_pkg::*;
#(
  parameter int CNT_W = 21
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CH_SEL_W-1:0]          rd_ch,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ch_bins,
  output logic [CNT_W-1:0]             rd_data
);
  logic [CNT_W-1:0] sel_bin;

  always_comb begin
    case (ch_sel_e'(rd_ch))
      CH_RED:   sel_bin = ch_bins[0];
      CH_GREEN: sel_bin = ch_bins[1];
      CH_BLUE:  sel_bin = ch_bins[2];
      default:  sel_bin = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel_bin;
  end
endmodule

// File: rtl/rgb_hist_engine.sv
`timescale 1ns/1ps
module rgb_hist_engine
  import rgb_hist_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int CNT_W = 21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pix_de,
  input  logic                    pix_vsync,
  input  logic [NUM_CH*PIX_W-1:0] pix_rgb,
  input  logic [CH_SEL_W-1:0]     rd_ch,
  input  logic [PIX_W-1:0]        rd_addr,
  output logic [CNT_W-1:0]        rd_data,
  output logic                    frame_done
);
  logic                         swap;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_bins;

  hist_frame_sync u_sync (
    .clk        (clk),
    .rst        (rst),
    .vsync_in   (pix_vsync),
    .swap       (swap),
    .bank_ready (frame_done)
  );

  // Channel 0 takes the top byte (red), channel NUM_CH-1 the bottom byte (blue).
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hist_channel #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .pix_val (pix_rgb[(NUM_CH-1-c)*PIX_W +: PIX_W]),
      .pix_en  (pix_de),
      .swap    (swap),
      .rd_addr (rd_addr),
      .rd_bin  (ch_bins[c])
    );
  end

  hist_read_port #(.CNT_W(CNT_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_ch   (rd_ch),
    .ch_bins (ch_bins),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/rgb_hist_engine_chk.sv
`timescale 1ns/1ps
module rgb_hist_engine_chk #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_vsync,
  input logic [1:0]       rd_ch,
  input logic [PIX_W-1:0] rd_addr,
  input logic [CNT_W-1:0] rd_data,
  input logic             frame_done
);
  logic       vs_seen;
  logic       rise_seen;
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_seen   <= 1'b0;
      rise_seen <= 1'b0;
      age       <= 2'd0;
    end else begin
      vs_seen   <= pix_vsync;
      rise_seen <= pix_vsync && !vs_seen;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  // R4: the ready pulse never lasts two clocks
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R4: the ready pulse follows each vsync rising edge and nothing else
  assert_pulse_tracks_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (frame_done == rise_seen));

  // R7: the unused channel select reads as zero
  assert_unused_channel_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_ch == 2'd3) |=> (rd_data == '0));

  // R6: held data stays put while nothing about the read changes and no swap occurs
  assert_hold_between_swaps_R6: assert property (@(posedge clk) disable iff (rst)
    ((age == 2'd3) && (rd_ch == $past(rd_ch)) && (rd_addr == $past(rd_addr)) && !frame_done)
      |=> $stable(rd_data));
endmodule

bind rgb_hist_engine rgb_hist_engine_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pix_vsync  (pix_vsync),
  .rd_ch      (rd_ch),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .frame_done (frame_done)
);

// File: tb/rgb_hist_engine_bench.sv
`timescale 1ns/1ps
module rgb_hist_engine_bench;
  localparam int PIX_W = 8;
  localparam int CNT_W = 21;
  localparam int BINS  = 256;

  logic             clk = 1'b0;
  logic             rst;
  logic             pix_de;
  logic             pix_vsync;
  logic [23:0]      pix_rgb;
  logic [1:0]       rd_ch;
  logic [PIX_W-1:0] rd_addr;
  logic [CNT_W-1:0] rd_data;
  logic             frame_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  int exp_live [3][BINS];
  int exp_bank [3][BINS];

  always #2.5 clk = ~clk;

  rgb_hist_engine #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_rgb_hist_engine (
    .clk (clk), .rst (rst), .pix_de (pix_de), .pix_vsync (pix_vsync),
    .pix_rgb (pix_rgb), .rd_ch (rd_ch), .rd_addr (rd_addr),
    .rd_data (rd_data), .frame_done (frame_done)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int actual, int expected);
    n_tests++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic model_add(logic [23:0] rgb);
    exp_live[0][rgb[23:16]]++;
    exp_live[1][rgb[15:8]]++;
    exp_live[2][rgb[7:0]]++;
  endtask

  task automatic model_swap();
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < BINS; b++) begin
        exp_bank[c][b] = exp_live[c][b];
        exp_live[c][b] = 0;
      end
  endtask

  task automatic pixel(bit de, logic [23:0] rgb);
    pix_de  = de;
    pix_rgb = rgb;
    if (de) model_add(rgb);
    tick();
    pix_de = 1'b0;
  endtask

  task automatic frame_end(string req);
    pix_vsync = 1'b1;
    pix_de    = 1'b0;
    model_swap();
    tick();
    chk({req, " frame_done high after vsync edge"}, int'(frame_done), 1);
    tick();
    chk({req, " frame_done single cycle"}, int'(frame_done), 0);
    pix_vsync = 1'b0;
    tick();
  endtask

  task automatic read_bin(int c, int b, output int val);
    rd_ch   = 2'(c);
    rd_addr = 8'(b);
    tick();
    val = int'(rd_data);
  endtask

  task automatic check_bank(string req);
    int v;
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < BINS; b++) begin
        read_bin(c, b, v);
        chk(req, v, exp_bank[c][b]);
      end
  endtask

  // R1: reset state
  task automatic t_reset();
    chk("R1 frame_done at reset", int'(frame_done), 0);
    chk("R1 rd_data at reset", int'(rd_data), 0);
    check_bank("R1 held bank cleared");
  endtask

  // R2, R3: mixed pixels with blanked ones
  task automatic t_mixed_frame();
    for (int i = 0; i < 300; i++) begin
      if (i % 5 == 0) pixel(1'b0, 24'hAAAAAA);
      else pixel(1'b1, {8'(i), 8'(i * 3), 8'(255 - i)});
    end
    frame_end("R4");
    begin
      int v;
      read_bin(0, 8'hAA, v);
      chk("R3 blanked value not counted", v, exp_bank[0][8'hAA]);
    end
    check_bank("R2 per-channel bin counts");
  endtask

  // R5, R6: pixel in the swap cycle, vsync held high, old bank persists
  task automatic t_swap_cycle();
    int v;
    for (int i = 0; i < 40; i++) pixel(1'b1, 24'h050607);
    pix_vsync = 1'b1;
    model_swap();
    pixel(1'b1, 24'h112233);
    chk("R4 frame_done after edge with active pixel", int'(frame_done), 1);
    for (int i = 0; i < 5; i++) begin
      pixel(1'b1, 24'h112233);
      chk("R6 no pulse while vsync held", int'(frame_done), 0);
    end
    pix_vsync = 1'b0;
    pixel(1'b1, 24'h445566);
    chk("R6 no pulse on vsync fall", int'(frame_done), 0);
    read_bin(0, 8'h05, v);
    chk("R6 previous frame still held", v, 40);
    read_bin(0, 8'h11, v);
    chk("R6 new frame not yet visible", v, 0);
    frame_end("R4");
    read_bin(0, 8'h11, v);
    chk("R5 swap-cycle pixel in new frame", v, 6);
    read_bin(2, 8'h07, v);
    chk("R5 counts restarted from zero", v, 0);
    check_bank("R5 bank after restart");
  endtask

  // R7: latency and unused select
  task automatic t_read_port();
    int v;
    read_bin(1, 8'h22, v);
    chk("R7 green bin", v, 6);
    rd_ch = 2'd2;
    rd_addr = 8'h66;
    #1;
    chk("R7 output unchanged before edge", int'(rd_data), 6);
    tick();
    chk("R7 blue bin after one edge", int'(rd_data), 1);
    for (int b = 0; b < 4; b++) begin
      read_bin(3, 8'h22 + b * 68, v);
      chk("R7 unused select returns zero", v, 0);
    end
  endtask

  // R2: full-length ramp lines with horizontal blanking
  task automatic t_ramp_lines();
    for (int ln = 0; ln < 4; ln++) begin
      for (int p = 0; p < 1280; p++)
        pixel(1'b1, {8'(p), 8'(p + ln), 8'(p >> 2)});
      for (int h = 0; h < 16; h++) pixel(1'b0, 24'h000000);
    end
    frame_end("R4");
    check_bank("R2 ramp line counts");
  endtask

  initial begin
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < BINS; b++) begin
        exp_live[c][b] = 0;
        exp_bank[c][b] = 0;
      end
    rst = 1'b1; pix_de = 1'b0; pix_vsync = 1'b0; pix_rgb = '0;
    rd_ch = 2'd0; rd_addr = '0;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_mixed_frame();
    t_swap_cycle();
    t_read_port();
    t_ramp_lines();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule